// File: doc/BRIEF.md
# Fractional-Divider PWM Timebase

This block is the shared timebase for a group of PWM channels. It takes a set of source-rate strobes, picks one of them, and divides that strobe rate by a fixed-point divider that has eight fractional bits. Each divided tick advances a free-running up-counter. The counter wraps at a programmable bit width, and it raises a single-cycle overflow flag on the wrap. The compare channels downstream read the count and the flag. The block does not generate the PWM outputs itself.

Configuration is written through a strobe-qualified interface that carries a source selector, an 18-bit divider and a resolution field. In immediate mode a write takes effect on the next clock. In deferred mode a write lands only in a holding copy, and it moves into the working configuration when the commit strobe is pulsed. A separate restart input clears the counter and the fractional phase, so that software can align several timers. Illegal divider or resolution values are dropped field by field, and the working value of that field is kept.

Top module: `pwmtb_timer`

## Requirements
- R1: After reset, `cnt` is 0 and `ovf` is 0. The working configuration is source 0, divider 0x100 (one tick per source strobe) and resolution 14.
- R2: The divider D is split into I = D[17:8] and F = D[7:0]. Counting from a restart, tick k (k >= 1) falls on source strobe number k*I + floor((k-1)*F/256). Each tick adds one to the counter.
- R3: With resolution r, the counter counts 0, 1, …, 2^r − 1 and then returns to 0. A value at or above 2^r − 1 also returns to 0 on the next tick.
- R4: `ovf` is high for exactly the one cycle in which the counter shows 0 as the result of a wrap, and it is low at every other time.
- R5: A divider value below 0x100 is not applied. The working divider keeps its previous value, and the other fields of the same write still apply.
- R6: A resolution value of 0 or above 14 is not applied. The working resolution keeps its previous value.
- R7: While `low_speed` is 1, writes change only the held copy, and the timer keeps using the old configuration until `cfg_update` is pulsed.
- R8: While `low_speed` is 0, an accepted write is used from the next cycle on, with no `cfg_update` pulse.
- R9: `timer_rst` clears the counter and the fractional phase on the next edge. While it stays high, `cnt` stays 0 and `ovf` stays 0, even if strobes arrive.
- R10: Only strobes on `src_en[sel]` advance the divider, where sel is the working 2-bit source selector. Strobes on the other sources have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| low_speed | input | 1 | 1 = deferred (commit-strobe) configuration, 0 = immediate |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Source selector to write |
| cfg_div | input | 18 | Divider to write, 10.8 fixed point |
| cfg_res | input | 4 | Counter resolution in bits to write |
| cfg_update | input | 1 | Commit held configuration (deferred mode) |
| timer_rst | input | 1 | Clear counter and fractional phase |
| src_en | input | 4 | One strobe per selectable source |
| cnt | output | 14 | Current counter value |
| ovf | output | 1 | One-cycle wrap flag |

## Verification
A corrupted fraction accumulator or period register shows up at `cnt` as a tick count that drifts from the closed-form count of R2. That drift is visible within one or two ticks of a restart with a fractional divider. A wrong working configuration changes the wrap point or the tick rate, so the error appears within the first counter period after the restart that follows the write. The bench compares `cnt` and `ovf` with values computed from the requirements after counted runs of strobes. Those runs use random dividers, random sources and random strobe patterns.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

    localparam int SRC_W   = 2;
    localparam int N_SRC   = 1 << SRC_W;
    localparam int DIV_W   = 18;
    localparam int FRAC_W  = 8;
    localparam int INT_W   = DIV_W - FRAC_W;
    localparam int SPAN_W  = INT_W + 1;
    localparam int RES_MAX = 14;
    localparam int RES_W   = 4;
    localparam int CNT_W   = RES_MAX;

    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(1 << FRAC_W);

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic [RES_W-1:0] res;
    } tcfg_t;

    localparam tcfg_t CFG_RESET = '{src: '0, div: DIV_MIN, res: RES_W'(RES_MAX)};

    function automatic logic div_ok(input logic [DIV_W-1:0] d);
        return d >= DIV_MIN;
    endfunction

    function automatic logic res_ok(input logic [RES_W-1:0] r);
        return (r != '0) && (r <= RES_W'(RES_MAX));
    endfunction

    // Apply a write request onto a base configuration, keeping illegal fields.
    function automatic tcfg_t merge_cfg(input tcfg_t base, input tcfg_t req);
        tcfg_t o;
        o     = base;
        o.src = req.src;
        if (div_ok(req.div)) o.div = req.div;
        if (res_ok(req.res)) o.res = req.res;
        return o;
    endfunction

    function automatic logic [CNT_W-1:0] wrap_of(input logic [RES_W-1:0] r);
        logic [CNT_W-1:0] w;
        w = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(r)) w[i] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/pwmtb_cfg.sv
module pwmtb_cfg
    import pwmtb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  low_speed,
    input  logic  wr,
    input  tcfg_t wr_cfg,
    input  logic  update,
    output tcfg_t act
);

    tcfg_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= CFG_RESET;
            act  <= CFG_RESET;
        end else begin
            if (wr) held <= merge_cfg(held, wr_cfg);
            if (!low_speed) begin
                if (wr) act <= merge_cfg(act, wr_cfg);
            end else if (update) begin
                act <= held;
            end
        end
    end

    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
        act.div >= DIV_MIN); // R5
    AST_RES_LEGAL: assert property (@(posedge clk) disable iff (rst)
        act.res != '0 && act.res <= RES_W'(RES_MAX)); // R6
    AST_LS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (low_speed && !update) |=> act == $past(act)); // R7
    AST_HS_APPLY: assert property (@(posedge clk) disable iff (rst)
        (!low_speed && wr && wr_cfg.div >= DIV_MIN) |=> act.div == $past(wr_cfg.div)); // R8

endmodule

// File: rtl/pwmtb_frac_div.sv
module pwmtb_frac_div
    import pwmtb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_rst,
    input  logic             src_pulse,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [SPAN_W-1:0] pos;
    logic [SPAN_W-1:0] span;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic [SPAN_W-1:0] int_part;

    assign int_part = {1'b0, div[DIV_W-1:FRAC_W]};
    assign acc_sum  = {1'b0, acc} + {1'b0, div[FRAC_W-1:0]};
    assign tick     = src_pulse && ((pos + SPAN_W'(1)) >= span);

    always_ff @(posedge clk) begin
        if (rst || phase_rst) begin
            pos  <= '0;
            acc  <= '0;
            span <= int_part;
        end else if (tick) begin
            pos  <= '0;
            acc  <= acc_sum[FRAC_W-1:0];
            span <= int_part + SPAN_W'(acc_sum[FRAC_W]);
        end else if (src_pulse) begin
            pos  <= pos + SPAN_W'(1);
        end
    end

    AST_SPAN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        span != '0); // R2

endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
    import pwmtb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] wrap,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (tick) begin
            if (cnt >= wrap) begin
                cnt <= '0;
                ovf <= 1'b1;
            end else begin
                cnt <= cnt + CNT_W'(1);
                ovf <= 1'b0;
            end
        end else begin
            ovf <= 1'b0;
        end
    end

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf |-> cnt == '0); // R4
    AST_WRAP_FROM_TOP: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(cnt) >= $past(wrap)); // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && !ovf)); // R9

endmodule

// File: rtl/pwmtb_timer.sv
module pwmtb_timer
    import pwmtb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             low_speed,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_src,
    input  logic [17:0]      cfg_div,
    input  logic [3:0]       cfg_res,
    input  logic             cfg_update,
    input  logic             timer_rst,
    input  logic [3:0]       src_en,
    output logic [13:0]      cnt,
    output logic             ovf
);

    tcfg_t            req;
    tcfg_t            act;
    logic             src_pulse;
    logic             tick;
    logic [CNT_W-1:0] wrap;

    assign req = '{src: cfg_src, div: cfg_div, res: cfg_res};

    pwmtb_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .low_speed (low_speed),
        .wr        (cfg_wr),
        .wr_cfg    (req),
        .update    (cfg_update),
        .act       (act)
    );

    assign src_pulse = src_en[act.src];
    assign wrap      = wrap_of(act.res);

    pwmtb_frac_div u_div (
        .clk       (clk),
        .rst       (rst),
        .phase_rst (timer_rst),
        .src_pulse (src_pulse),
        .div       (act.div),
        .tick      (tick)
    );

    pwmtb_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (timer_rst),
        .tick (tick),
        .wrap (wrap),
        .cnt  (cnt),
        .ovf  (ovf)
    );

    AST_IDLE_SRC: assert property (@(posedge clk) disable iff (rst)
        (!timer_rst && !src_en[act.src]) |=> $stable(cnt)); // R10

endmodule

// File: tb/sim_pwmtb_timer.sv
`timescale 1ns/1ps
module sim_pwmtb_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        low_speed = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_src = '0;
    logic [17:0] cfg_div = '0;
    logic [3:0]  cfg_res = '0;
    logic        cfg_update = 1'b0;
    logic        timer_rst = 1'b0;
    logic [3:0]  src_en = '0;
    logic [13:0] cnt;
    logic        ovf;

    int total = 0;
    int bad   = 0;
    int pulses [4];

    always #4 clk = ~clk;

    pwmtb_timer u0 (
        .clk(clk), .rst(rst), .low_speed(low_speed), .cfg_wr(cfg_wr),
        .cfg_src(cfg_src), .cfg_div(cfg_div), .cfg_res(cfg_res),
        .cfg_update(cfg_update), .timer_rst(timer_rst), .src_en(src_en),
        .cnt(cnt), .ovf(ovf)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Ticks after n selected strobes from a restart, per R2.
    function automatic longint ticks_after(input longint n, input longint d);
        longint ip = d >> 8;
        longint fr = d & 255;
        longint k  = 0;
        while (((k + 1) * ip + ((k * fr) >> 8)) <= n) k++;
        return k;
    endfunction

    task automatic write_cfg(input int s, input int d, input int r);
        cfg_wr = 1'b1; cfg_src = 2'(s); cfg_div = 18'(d); cfg_res = 4'(r);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic commit();
        cfg_update = 1'b1;
        @(negedge clk);
        cfg_update = 1'b0;
    endtask

    task automatic restart();
        src_en = '0;
        timer_rst = 1'b1;
        @(negedge clk);
        timer_rst = 1'b0;
        for (int i = 0; i < 4; i++) pulses[i] = 0;
    endtask

    task automatic step(input int n, input bit rnd, input logic [3:0] fixed);
        for (int i = 0; i < n; i++) begin
            src_en = rnd ? 4'($urandom_range(0, 15) | $urandom_range(0, 15)) : fixed;
            @(negedge clk);
            for (int b = 0; b < 4; b++) if (src_en[b]) pulses[b]++;
        end
        src_en = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 cnt in reset", cnt, 0);
        chk("R1 ovf in reset", ovf, 0);
        rst = 1'b0;
        step(5, 1'b0, 4'h0);
        chk("R1 cnt idle", cnt, 0);
        chk("R1 ovf idle", ovf, 0);
        // default: source 0, divide by 1, 14 bits
        restart();
        step(20, 1'b0, 4'h1);
        chk("R1 default rate", cnt, 20);

        // R3 / R4: resolution 3 wraps after 7
        write_cfg(0, 'h100, 3);
        restart();
        step(7, 1'b0, 4'h1);
        chk("R3 top value", cnt, 7);
        chk("R4 no ovf at top", ovf, 0);
        step(1, 1'b0, 4'h1);
        chk("R3 wrap to zero", cnt, 0);
        chk("R4 ovf on wrap", ovf, 1);
        step(1, 1'b0, 4'h1);
        chk("R4 ovf one cycle", ovf, 0);
        chk("R3 count after wrap", cnt, 1);

        // R5: illegal divider dropped
        write_cfg(0, 'h200, 3);
        write_cfg(0, 'h0FF, 3);
        write_cfg(0, 'h000, 3);
        restart();
        step(20, 1'b0, 4'h1);
        chk("R5 divider kept", cnt, ticks_after(20, 'h200) % 8);

        // R6: illegal resolution dropped
        write_cfg(0, 'h100, 0);
        write_cfg(0, 'h100, 15);
        restart();
        step(9, 1'b0, 4'h1);
        chk("R6 resolution kept", cnt, 1);

        // R7: deferred mode
        low_speed = 1'b1;
        write_cfg(0, 'h200, 4);
        restart();
        step(12, 1'b0, 4'h1);
        chk("R7 held before commit", cnt, 12 % 8);
        commit();
        restart();
        step(12, 1'b0, 4'h1);
        chk("R7 applied after commit", cnt, ticks_after(12, 'h200));

        // R8: immediate mode
        low_speed = 1'b0;
        write_cfg(0, 'h100, 5);
        restart();
        step(40, 1'b0, 4'h1);
        chk("R8 immediate apply", cnt, 40 % 32);

        // R9: restart held while strobes arrive
        timer_rst = 1'b1;
        src_en = 4'hF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 cnt held", cnt, 0);
            chk("R9 ovf held", ovf, 0);
        end
        timer_rst = 1'b0;
        src_en = '0;
        step(3, 1'b0, 4'h1);
        chk("R9 resumes", cnt, 3);

        // R10: unselected sources ignored
        write_cfg(2, 'h100, 14);
        restart();
        step(20, 1'b0, 4'hB);
        chk("R10 other sources ignored", cnt, 0);
        step(6, 1'b0, 4'h4);
        chk("R10 selected source", cnt, 6);

        // R2 / R10: random dividers, sources and strobe patterns
        for (int it = 0; it < 16; it++) begin
            int d = 'h100 + $urandom_range(0, 'h6FF);
            int s = $urandom_range(0, 3);
            int n = 40 + $urandom_range(0, 200);
            write_cfg(s, d, 14);
            restart();
            step(n, 1'b1, 4'h0);
            chk($sformatf("R2 R10 d=%0h s=%0d", d, s), cnt, ticks_after(pulses[s], d) % 16384);
        end

        // R2: largest divider
        write_cfg(0, 'h3FFFF, 14);
        restart();
        step(2100, 1'b0, 4'h1);
        chk("R2 max divider", cnt, ticks_after(2100, 'h3FFFF));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule